// File: doc/BRIEF.md
# DS3 Receive Alarm Interrupt Register File

This block holds the interrupt and status registers for the receive side of a DS3 framer. It takes level inputs from the framer for the far-end failure indication, the alarm indication channel bit and the out-of-frame state. It also takes single-cycle pulses for P-bit parity errors and for the validate and remove events of a far-end alarm and control (FEAC) code processor, together with the 6-bit code that processor has accepted. A change of any level, in either direction, and every pulse is latched into a status bit. The bit stays set until the processor reads the register that holds it.

A small synchronous CPU port gives access to four byte registers: alarm enables, alarm status, the FEAC code, and a combined FEAC control and status register. Read data is a combinational function of the address. A read has a side effect only in the cycle where the read strobe is high, and that side effect happens at the clock edge that ends that cycle. A single interrupt output is raised whenever a status bit and its enable bit are both set.

Top module: `rx_alarm_irq_regs`

## Requirements
- R1: After reset, the alarm enable register (0x10) and alarm status register (0x11) read 0x00, the FEAC code register (0x12) reads 0x7E, the FEAC control register (0x13) reads 0x00 and irq_o is 0.
- R2: Alarm status bit 3 latches on any change of ferf_i, bit 2 on any change of aic_i, and bit 1 on any change of oof_i, in either direction. Bit 0 latches on a pbit_err_i pulse. Each level is compared with its value in the previous cycle, and that previous value is 0 after reset.
- R3: A status bit stays set until a cycle with cpu_rd high at its register's address. At that cycle's clock edge, every status bit of that register clears, and the read returns the value held before the clear.
- R4: If a status event arrives in the same cycle as a clearing read of its register, the bit is set after that edge.
- R5: Bits 3:0 of register 0x10 are read/write enables for the alarm status bits of the same position. Bits 7:4 read 0.
- R6: A feac_valid_i pulse loads feac_code_i into bits 6:1 of register 0x12. Bits 7 and 0 always read 0. A feac_remove_i pulse without a validate restores 0x7E.
- R7: Bit 4 of register 0x13 reads 1 from a validate until a remove. When validate and remove arrive together, the validate wins for both the code and this bit.
- R8: Bit 0 of register 0x13 latches on each validate and bit 2 on each remove. Both follow the read-clear rules of R3 and R4.
- R9: Bits 3 (remove enable) and 1 (validate enable) of register 0x13 are read/write. CPU writes to every other bit of 0x13, and to registers 0x11 and 0x12, have no effect.
- R10: irq_o is 1 exactly when some status bit and its enable bit are both 1. It follows the registered state in the same cycle.
- R11: Any address other than 0x10 to 0x13 reads 0x00. Reads and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ferf_i | input | 1 | Far-end failure condition level from the framer |
| aic_i | input | 1 | Received alarm indication channel bit level |
| oof_i | input | 1 | Out-of-frame state level |
| pbit_err_i | input | 1 | One-cycle pulse per detected P-bit error |
| feac_valid_i | input | 1 | One-cycle pulse when a FEAC code is validated |
| feac_remove_i | input | 1 | One-cycle pulse when the validated code is removed |
| feac_code_i | input | 6 | Code that accompanies feac_valid_i |
| cpu_addr | input | 8 | Register address |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data for cpu_addr |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded properties check four things: a latched status bit is held until its clearing read, an event always lands in its status bit even when it coincides with a read, a read with no coinciding event empties the register, and validate and remove leave the code register and the present flag in the expected state. They also confirm that the interrupt stays low while all enables are zero, and that unmapped addresses read zero. Only the bench scenarios can show the rest: changes detected in both directions of each level, the exact byte layout of each register, that writes to status and code fields are ignored, and the priority when validate and remove arrive in the same cycle. The bench shows these by comparing every cycle against a behavioural model.

// File: rtl/rxalm_pkg.sv
package rxalm_pkg;
  // alarm status / enable bit positions (0x10 / 0x11)
  localparam int ALM_N    = 4;
  localparam int IDX_PBIT = 0;
  localparam int IDX_OOF  = 1;
  localparam int IDX_AIC  = 2;
  localparam int IDX_FERF = 3;
  // level inputs watched for change, packed {ferf, aic, oof}
  localparam int LVL_N    = 3;
  // FEAC event vector order
  localparam int FEV_VALID  = 0;
  localparam int FEV_REMOVE = 1;
  localparam int FEV_N      = 2;
  // FEAC control register (0x13) bit positions
  localparam int B_VLD_STS = 0;
  localparam int B_VLD_EN  = 1;
  localparam int B_RMV_STS = 2;
  localparam int B_RMV_EN  = 3;
  localparam int B_PRESENT = 4;
endpackage

// File: rtl/rxalm_chg_det.sv
module rxalm_chg_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] prev_q;

  // previous-cycle copy of every level; reset value 0 (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign chg_o[i] = lvl_i[i] ^ prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/rxalm_rur_bits.sv
module rxalm_rur_bits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  // event wins over a coinciding clear (R4)
  always_comb begin
    q_d = q_q;
    if (clr_i) q_d = '0;
    q_d = q_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)))
    else $error("status event not latched");

  p_held_until_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i) |=> ((q_o & $past(q_o)) == $past(q_o)))
    else $error("status bit lost without read");

  p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (set_i == '0)) |=> (q_o == '0))
    else $error("status not cleared by read");
endmodule

// File: rtl/rxalm_feac_reg.sv
module rxalm_feac_reg #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              remove_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              present_o
);
  localparam logic [CODE_W-1:0] CODE_CLEAR = '1;

  logic [CODE_W-1:0] code_d, code_q;
  logic              pres_d, pres_q;

  // validate has priority over remove (R7)
  always_comb begin
    code_d = code_q;
    pres_d = pres_q;
    if (valid_i) begin
      code_d = code_i;
      pres_d = 1'b1;
    end else if (remove_i) begin
      code_d = CODE_CLEAR;
      pres_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_CLEAR;
      pres_q <= 1'b0;
    end else begin
      code_q <= code_d;
      pres_q <= pres_d;
    end
  end

  assign code_o    = code_q;
  assign present_o = pres_q;

  p_remove_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (remove_i && !valid_i) |=> ((code_o == CODE_CLEAR) && !present_o))
    else $error("remove did not restore code");

  p_validate_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (present_o && (code_o == $past(code_i))))
    else $error("validate did not load code");
endmodule

// File: rtl/rx_alarm_irq_regs.sv
module rx_alarm_irq_regs
  import rxalm_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter int              CODE_W      = 6,
  parameter logic [ADDR_W-1:0] A_ALM_EN    = 8'h10,
  parameter logic [ADDR_W-1:0] A_ALM_STS   = 8'h11,
  parameter logic [ADDR_W-1:0] A_FEAC_CODE = 8'h12,
  parameter logic [ADDR_W-1:0] A_FEAC_CTL  = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ferf_i,
  input  logic              aic_i,
  input  logic              oof_i,
  input  logic              pbit_err_i,
  input  logic              feac_valid_i,
  input  logic              feac_remove_i,
  input  logic [CODE_W-1:0] feac_code_i,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq_o
);
  localparam int CODE_LSB = 1;
  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

  // ---------------- decode
  logic hit_en, hit_sts, hit_code, hit_ctl;
  assign hit_en   = (cpu_addr == A_ALM_EN);
  assign hit_sts  = (cpu_addr == A_ALM_STS);
  assign hit_code = (cpu_addr == A_FEAC_CODE);
  assign hit_ctl  = (cpu_addr == A_FEAC_CTL);

  // ---------------- change detection on levels
  logic [LVL_N-1:0] lvl, lvl_chg;
  assign lvl = {ferf_i, aic_i, oof_i};

  rxalm_chg_det #(.N(LVL_N)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lvl),
    .chg_o (lvl_chg)
  );

  logic [ALM_N-1:0] alm_set;
  always_comb begin
    alm_set           = '0;
    alm_set[IDX_PBIT] = pbit_err_i;
    alm_set[IDX_OOF]  = lvl_chg[0];
    alm_set[IDX_AIC]  = lvl_chg[1];
    alm_set[IDX_FERF] = lvl_chg[2];
  end

  // ---------------- alarm status (read-clear)
  logic [ALM_N-1:0] alm_sts;
  rxalm_rur_bits #(.W(ALM_N)) u_alm_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (alm_set),
    .clr_i (cpu_rd && hit_sts),
    .q_o   (alm_sts)
  );

  // ---------------- FEAC code and presence
  logic [CODE_W-1:0] feac_code;
  logic              feac_present;
  rxalm_feac_reg #(.CODE_W(CODE_W)) u_feac (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (feac_valid_i),
    .remove_i  (feac_remove_i),
    .code_i    (feac_code_i),
    .code_o    (feac_code),
    .present_o (feac_present)
  );

  // ---------------- FEAC event status (read-clear)
  logic [FEV_N-1:0] fev_set, fev_sts;
  always_comb begin
    fev_set             = '0;
    fev_set[FEV_VALID]  = feac_valid_i;
    fev_set[FEV_REMOVE] = feac_remove_i;
  end

  rxalm_rur_bits #(.W(FEV_N)) u_fev_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (fev_set),
    .clr_i (cpu_rd && hit_ctl),
    .q_o   (fev_sts)
  );

  // ---------------- enable registers
  logic [ALM_N-1:0] alm_en_d, alm_en_q;
  logic [FEV_N-1:0] fev_en_d, fev_en_q;

  always_comb begin
    alm_en_d = alm_en_q;
    fev_en_d = fev_en_q;
    if (cpu_wr && hit_en) alm_en_d = cpu_wdata[ALM_N-1:0];
    if (cpu_wr && hit_ctl) begin
      fev_en_d[FEV_VALID]  = cpu_wdata[B_VLD_EN];
      fev_en_d[FEV_REMOVE] = cpu_wdata[B_RMV_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_en_q <= '0;
      fev_en_q <= '0;
    end else begin
      alm_en_q <= alm_en_d;
      fev_en_q <= fev_en_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^cpu_wdata[DATA_W-1:ALM_N];

  // ---------------- read mux
  always_comb begin
    cpu_rdata = '0;
    if (hit_en) begin
      cpu_rdata[ALM_N-1:0] = alm_en_q;
    end else if (hit_sts) begin
      cpu_rdata[ALM_N-1:0] = alm_sts;
    end else if (hit_code) begin
      cpu_rdata[CODE_MSB:CODE_LSB] = feac_code;
    end else if (hit_ctl) begin
      cpu_rdata[B_VLD_STS] = fev_sts[FEV_VALID];
      cpu_rdata[B_VLD_EN]  = fev_en_q[FEV_VALID];
      cpu_rdata[B_RMV_STS] = fev_sts[FEV_REMOVE];
      cpu_rdata[B_RMV_EN]  = fev_en_q[FEV_REMOVE];
      cpu_rdata[B_PRESENT] = feac_present;
    end
  end

  // ---------------- interrupt
  assign irq_o = (|(alm_sts & alm_en_q)) | (|(fev_sts & fev_en_q));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((alm_en_q == '0) && (fev_en_q == '0)) |-> !irq_o)
    else $error("interrupt with all enables clear");

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_en || hit_sts || hit_code || hit_ctl) |-> (cpu_rdata == '0))
    else $error("unmapped address returned data");

  p_code_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_code |-> (cpu_rdata[0] == 1'b0 && cpu_rdata[DATA_W-1] == 1'b0))
    else $error("code register pad bits set");
endmodule

// File: tb/rx_alarm_irq_regs_tb.sv
module rx_alarm_irq_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ferf_i = 0, aic_i = 0, oof_i = 0, pbit_err_i = 0;
  logic       feac_valid_i = 0, feac_remove_i = 0;
  logic [5:0] feac_code_i = '0;
  logic [7:0] cpu_addr = '0;
  logic       cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       irq_o;

  always #2 clk = ~clk; // 250 MHz

  rx_alarm_irq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .ferf_i(ferf_i), .aic_i(aic_i), .oof_i(oof_i),
    .pbit_err_i(pbit_err_i), .feac_valid_i(feac_valid_i),
    .feac_remove_i(feac_remove_i), .feac_code_i(feac_code_i),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .irq_o(irq_o)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  // behavioural reference state
  int m_alm_en, m_alm_st, m_prev_f, m_prev_a, m_prev_o;
  int m_code, m_present, m_fen_v, m_fen_r, m_fst_v, m_fst_r;

  function automatic int exp_rdata(int a);
    case (a)
      'h10: return m_alm_en;
      'h11: return m_alm_st;
      'h12: return m_code;
      'h13: return m_fst_v + 2*m_fen_v + 4*m_fst_r + 8*m_fen_r + 16*m_present;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_irq();
    return ((m_alm_st & m_alm_en) != 0) || (m_fst_v && m_fen_v) || (m_fst_r && m_fen_r);
  endfunction

  task automatic model_reset();
    m_alm_en = 0; m_alm_st = 0; m_prev_f = 0; m_prev_a = 0; m_prev_o = 0;
    m_code = 'h7E; m_present = 0; m_fen_v = 0; m_fen_r = 0; m_fst_v = 0; m_fst_r = 0;
  endtask

  task automatic model_step();
    int ev = 0;
    if (ferf_i != m_prev_f) ev |= 8;
    if (aic_i  != m_prev_a) ev |= 4;
    if (oof_i  != m_prev_o) ev |= 2;
    if (pbit_err_i) ev |= 1;
    if (cpu_rd && cpu_addr == 'h11) m_alm_st = 0;
    m_alm_st |= ev;
    if (cpu_rd && cpu_addr == 'h13) begin m_fst_v = 0; m_fst_r = 0; end
    if (feac_valid_i)  m_fst_v = 1;
    if (feac_remove_i) m_fst_r = 1;
    if (feac_valid_i) begin m_code = 2*feac_code_i; m_present = 1; end
    else if (feac_remove_i) begin m_code = 'h7E; m_present = 0; end
    if (cpu_wr && cpu_addr == 'h10) m_alm_en = cpu_wdata % 16;
    if (cpu_wr && cpu_addr == 'h13) begin
      m_fen_v = cpu_wdata[1];
      m_fen_r = cpu_wdata[3];
    end
    m_prev_f = ferf_i; m_prev_a = aic_i; m_prev_o = oof_i;
  endtask

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  // one clock: compare outputs mid-cycle, then advance model at the edge
  task automatic tick();
    #1;
    check("rdata", int'(cpu_rdata), exp_rdata(int'(cpu_addr)));
    check("irq", int'(irq_o), exp_irq());
    @(posedge clk);
    model_step();
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0; pbit_err_i = 0; feac_valid_i = 0; feac_remove_i = 0;
  endtask

  task automatic rd(int a);
    cpu_addr = a[7:0]; cpu_rd = 1; tick();
  endtask

  task automatic wr(int a, int d);
    cpu_addr = a[7:0]; cpu_wdata = d[7:0]; cpu_wr = 1; tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: reset values
    cur_req = "R1";
    for (int a = 'h10; a <= 'h13; a++) begin cpu_addr = a[7:0]; tick(); end
    // R2 + R3: P-bit pulse held until read, then cleared
    cur_req = "R2";
    pbit_err_i = 1; tick(); idle(3);
    cur_req = "R3"; rd('h11); rd('h11);
    // R2: OOF declared then cleared, both directions
    cur_req = "R2";
    oof_i = 1; idle(2); rd('h11); oof_i = 0; idle(1); rd('h11);
    aic_i = 1; tick(); aic_i = 0; tick(); rd('h11);
    ferf_i = 1; idle(2); rd('h11); ferf_i = 0; idle(2); rd('h11);
    // R5 + R10: enables and interrupt
    cur_req = "R5";
    wr('h10, 'hFF); rd('h10);
    cur_req = "R10";
    wr('h10, 'h02); pbit_err_i = 1; tick(); idle(1);
    oof_i = 1; tick(); idle(1); rd('h11); idle(1);
    // R4: event in the same cycle as the clearing read
    cur_req = "R4";
    aic_i = 1; pbit_err_i = 1; rd('h11); idle(1); rd('h11);
    // R6 + R7 + R8: validate then remove
    cur_req = "R6";
    feac_code_i = 6'h2A; feac_valid_i = 1; tick(); rd('h12);
    cur_req = "R8"; rd('h13); rd('h13);
    cur_req = "R6";
    feac_remove_i = 1; tick(); rd('h12);
    cur_req = "R8"; rd('h13);
    cur_req = "R7";
    feac_code_i = 6'h15; feac_valid_i = 1; feac_remove_i = 1; tick();
    rd('h12); rd('h13);
    feac_code_i = 6'h3F; feac_valid_i = 1; tick(); rd('h12);
    // R9: enables in 0x13; other writes ignored
    cur_req = "R9";
    wr('h10, 'h00);
    wr('h13, 'hFF); rd('h13);
    wr('h11, 'hFF); rd('h11); wr('h12, 'h00); rd('h12);
    cur_req = "R10";
    feac_remove_i = 1; tick(); idle(1); rd('h13); idle(1);
    feac_valid_i = 1; feac_code_i = 6'h01; tick(); idle(1);
    wr('h13, 'h00); idle(1); rd('h13);
    // R8 + R4: FEAC event during read
    cur_req = "R8";
    feac_valid_i = 1; rd('h13); rd('h13);
    // R11: unmapped addresses
    cur_req = "R11";
    wr('h55, 'hFF); rd('h55); rd('h00); rd('hFF); wr('h14, 'h0F);
    for (int a = 'h10; a <= 'h13; a++) begin cpu_addr = a[7:0]; tick(); end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule